// File: doc/BRIEF.md
# Four-Mode Synchronous Serial Shift Master

This block is a full-duplex synchronous serial master. For each transfer it asserts one active-low slave select, generates a shift clock from the system clock through a programmable divider, and shifts one data word out on `mosi` while sampling a word in from `miso`. The word goes out on the same clock edges that bring the incoming word in.

The idle level of the shift clock and the choice of launch and sample edges come from a small configuration. The four SPI clock polarity and phase combinations are available. A Microwire framing option is also available in two forms: standard shift clock and alternate shift clock. Each Microwire form is mapped onto the SPI mode that it matches.

The host writes the clock divider, the mode, the bit order and the slave index while the block is idle. It then pulses `start` with the transmit word. When `done` pulses, the host reads `rxWord`. A write-only transfer ignores `rxWord`, and a read-only transfer sends any dummy word. Slaves cannot acknowledge a word or stall the master, so every transfer takes a fixed number of cycles.

Top module: `shift_master`

## Requirements
- R1: After reset, `csN` is all ones, `busy`, `done` and `sclk` are 0, and `rxWord` is 0. The configuration resets to SPI mode 0, MSB first, divider 0 and slave 0.
- R2: While idle, `sclk` sits at the clock polarity of the stored configuration. The new level shows in the cycle after the configuration write.
- R3: With `cfgWire`=0, `cfgMode[1]` is the clock polarity and `cfgMode[0]` is the clock phase. With phase 0, the first bit is on `mosi` when the select falls; `miso` is sampled on the 1st, 3rd, 5th... clock edges and the next bit is launched on the 2nd, 4th... edges. With phase 1, bits are launched on the odd-numbered edges (from the 3rd) and sampled on the even-numbered edges.
- R4: With `cfgWire`=1, the clock idles low. If `cfgMode[0]`=0 (standard shift clock), the block behaves as SPI mode 1. If `cfgMode[0]`=1 (alternate shift clock), it behaves as SPI mode 0. `cfgMode[1]` is ignored.
- R5: If `cfgLsbFirst`=0, bit 7 of the word is sent and received first. If `cfgLsbFirst`=1, bit 0 is first.
- R6: Only the select bit `csN[cfgSlave]` goes low, with the slave index in binary. It stays low, without toggling, for the whole frame.
- R7: Let H = `cfgDiv`+1. The select falls in the cycle after `start` is taken. The first clock edge follows 2H cycles later, and the following edges come every H cycles. The select rises H cycles after the last edge, at the same moment that `busy` falls. A frame lasts (2·8+2)·H cycles.
- R8: `rxWord` holds the bits sampled from `miso` during the frame, in the configured bit order.
- R9: Configuration writes and `start` pulses are ignored while `busy` is high. The running frame and the next one use the settings stored before the frame began.
- R10: `done` is high for exactly one cycle when the select is released. `rxWord` is updated in that cycle and holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| txWord | input | DATA_W | Word to send, captured with start |
| cfgWe | input | 1 | Configuration write strobe (idle only) |
| cfgWire | input | 1 | 0: SPI framing, 1: Microwire framing |
| cfgMode | input | 2 | SPI: {polarity, phase}; Microwire: bit 0 alternate clock |
| cfgLsbFirst | input | 1 | Bit order select |
| cfgDiv | input | DIV_W | Half-period of shift clock minus one, in system cycles |
| cfgSlave | input | SEL_W | Binary index of the slave to select |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Shift clock |
| mosi | output | 1 | Serial data to slave |
| csN | output | NUM_SLV | Active-low slave selects |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse, received word valid |
| rxWord | output | DATA_W | Last received word |

## Verification
A wrong phase or edge counter shows at once on `sclk` or on `mosi`, within one half-period of the cycle where the model's edge count diverges. A wrong sample point goes unseen until the frame ends, when `rxWord` differs from the word the bench-side slave sent. Stored configuration that is corrupted by a write during a frame shows in the next idle `sclk` level and in the timing of the following frame. Each of these effects is caught because the bench predicts every output in every cycle.

// File: rtl/shift_pkg.sv
package shift_pkg;

  // Per-cycle strobes from the control sequencer to the datapath
  typedef struct packed {
    logic load;    // capture tx word, assert select
    logic toggle;  // shift clock edge
    logic sample;  // capture miso on this edge
    logic launch;  // advance mosi on this edge
    logic finish;  // release select, publish rx word
  } shift_stb_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } shift_st_e;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SEL_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               cfgWe,
  input  logic               cfgWire,
  input  logic [1:0]         cfgMode,
  input  logic               cfgLsbFirst,
  input  logic [DIV_W-1:0]   cfgDiv,
  input  logic [SEL_W-1:0]   cfgSlave,
  output shift_stb_t         stb,
  output logic               busy,
  output logic               cpol,
  output logic               lsbFirst,
  output logic [SEL_W-1:0]   slaveIdx
);

  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic [DIV_W-1:0]  divReg;
  logic [1:0]        modeReg;
  logic              wireReg;
  logic              cpha;
  logic [DIV_W-1:0]  halfCnt;
  logic [EDGE_W-1:0] edgeIdx;
  logic              tick;
  shift_st_e         state;

  // Microwire settings fold onto SPI modes: standard -> mode 1, alternate -> mode 0
  always_comb begin
    if (wireReg) begin
      cpol = 1'b0;
      cpha = ~modeReg[0];
    end else begin
      cpol = modeReg[1];
      cpha = modeReg[0];
    end
  end

  assign busy = (state != ST_IDLE);
  assign tick = (halfCnt == divReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg   <= '0;
      modeReg  <= '0;
      wireReg  <= 1'b0;
      lsbFirst <= 1'b0;
      slaveIdx <= '0;
    end else if (cfgWe && !busy && !start) begin
      divReg   <= cfgDiv;
      modeReg  <= cfgMode;
      wireReg  <= cfgWire;
      lsbFirst <= cfgLsbFirst;
      slaveIdx <= cfgSlave;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      edgeIdx <= '0;
    end else begin
      if (state == ST_IDLE) halfCnt <= '0;
      else if (tick)        halfCnt <= '0;
      else                  halfCnt <= halfCnt + 1'b1;
      unique case (state)
        ST_IDLE:  if (start) state <= ST_LEAD;
        ST_LEAD:  if (tick) begin
                    state   <= ST_SHIFT;
                    edgeIdx <= '0;
                  end
        ST_SHIFT: if (tick) begin
                    if (edgeIdx == LAST_EDGE) state <= ST_TRAIL;
                    else edgeIdx <= edgeIdx + 1'b1;
                  end
        ST_TRAIL: if (tick) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb        = '0;
    stb.load   = (state == ST_IDLE) && start;
    stb.toggle = (state == ST_SHIFT) && tick;
    stb.sample = stb.toggle && (edgeIdx[0] == cpha);
    stb.launch = stb.toggle && (edgeIdx[0] != cpha) &&
                 (cpha ? (edgeIdx != '0) : (edgeIdx != LAST_EDGE));
    stb.finish = (state == ST_TRAIL) && tick;
  end

  // R9: stored settings cannot move during a frame
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(divReg) && $stable(modeReg) && $stable(wireReg) &&
              $stable(lsbFirst) && $stable(slaveIdx)));

  // R7: a start while idle always opens a frame
  p_start_opens_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SLV = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  shift_stb_t         stb,
  input  logic               busy,
  input  logic               cpol,
  input  logic               lsbFirst,
  input  logic [SEL_W-1:0]   slaveIdx,
  input  logic [DATA_W-1:0]  txWord,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_SLV-1:0] csN,
  output logic [DATA_W-1:0]  rxWord,
  output logic               done
);

  logic [DATA_W-1:0] txSh;
  logic [DATA_W-1:0] rxSh;
  logic              sclkReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      sclkReg <= 1'b0;
      rxWord  <= '0;
      done    <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.load) begin
        txSh    <= txWord;
        sclkReg <= cpol;
      end else begin
        if (stb.toggle) sclkReg <= ~sclkReg;
        if (stb.launch) txSh <= lsbFirst ? (txSh >> 1) : (txSh << 1);
      end
      if (stb.sample)
        rxSh <= lsbFirst ? {miso, rxSh[DATA_W-1:1]} : {rxSh[DATA_W-2:0], miso};
      if (stb.finish) rxWord <= rxSh;
    end
  end

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_sel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           csN[i] <= 1'b1;
      else if (stb.load)   csN[i] <= (slaveIdx != SEL_W'(i));
      else if (stb.finish) csN[i] <= 1'b1;
    end
  end

  assign mosi = lsbFirst ? txSh[0] : txSh[DATA_W-1];
  assign sclk = busy ? sclkReg : cpol;

  // R6: never more than one slave selected
  p_one_select_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R6: selects hold still through the frame
  p_select_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.finish) |=> $stable(csN));

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: done coincides with release of all selects and end of busy
  p_done_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (&csN && !busy));

  // R3: the shift clock moves only on sequencer edge strobes
  p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.toggle) |=> $stable(sclkReg));

endmodule

// File: rtl/shift_master.sv
module shift_master
  import shift_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SLV = 4,
  parameter int DIV_W   = 8,
  parameter int SEL_W   = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [DATA_W-1:0]  txWord,
  input  logic               cfgWe,
  input  logic               cfgWire,
  input  logic [1:0]         cfgMode,
  input  logic               cfgLsbFirst,
  input  logic [DIV_W-1:0]   cfgDiv,
  input  logic [SEL_W-1:0]   cfgSlave,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_SLV-1:0] csN,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rxWord
);

  shift_stb_t       stb;
  logic             cpol;
  logic             lsbFirst;
  logic [SEL_W-1:0] slaveIdx;

  shift_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgWe(cfgWe), .cfgWire(cfgWire),
    .cfgMode(cfgMode), .cfgLsbFirst(cfgLsbFirst), .cfgDiv(cfgDiv),
    .cfgSlave(cfgSlave), .stb(stb), .busy(busy), .cpol(cpol),
    .lsbFirst(lsbFirst), .slaveIdx(slaveIdx)
  );

  shift_datapath #(.DATA_W(DATA_W), .NUM_SLV(NUM_SLV), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .cpol(cpol),
    .lsbFirst(lsbFirst), .slaveIdx(slaveIdx), .txWord(txWord), .miso(miso),
    .sclk(sclk), .mosi(mosi), .csN(csN), .rxWord(rxWord), .done(done)
  );

endmodule

// File: tb/shift_master_tb.sv
`timescale 1ns/1ps
module shift_master_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] txWord = '0;
  logic       cfgWe = 1'b0;
  logic       cfgWire = 1'b0;
  logic [1:0] cfgMode = '0;
  logic       cfgLsbFirst = 1'b0;
  logic [7:0] cfgDiv = '0;
  logic [1:0] cfgSlave = '0;
  logic       miso = 1'b0;
  logic       sclk, mosi, busy, done;
  logic [3:0] csN;
  logic [7:0] rxWord;

  shift_master #(.DATA_W(8), .NUM_SLV(4), .DIV_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .txWord(txWord), .cfgWe(cfgWe),
    .cfgWire(cfgWire), .cfgMode(cfgMode), .cfgLsbFirst(cfgLsbFirst),
    .cfgDiv(cfgDiv), .cfgSlave(cfgSlave), .miso(miso), .sclk(sclk),
    .mosi(mosi), .csN(csN), .busy(busy), .done(done), .rxWord(rxWord)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string tag = "R1 reset";

  // reference model state
  int         mDiv = 0;
  int         mSlv = 0;
  logic       mWire = 0, mLsb = 0;
  logic [1:0] mMode = 0;
  logic       active = 0;
  int         startCyc = 0;
  logic [7:0] mTx = 0, slvWord = 0, lastRx = 0;

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic polOf(input logic w, input logic [1:0] md);
    if (w) return 1'b0;
    return md[1];
  endfunction

  function automatic logic phaOf(input logic w, input logic [1:0] md);
    if (w) return (md[0] == 1'b0);   // standard -> mode 1, alternate -> mode 0
    return md[0];
  endfunction

  function automatic logic bitAt(input logic [7:0] w, input int i, input logic lsb);
    return lsb ? w[i] : w[7 - i];
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // cycle-by-cycle comparison plus the bench-side slave driving miso
  initial forever begin
    @(negedge clk);
    if (rstN) begin
      logic       pol, pha;
      logic [3:0] expCs;
      int m, hh, total, d, idx;
      pol = polOf(mWire, mMode);
      pha = phaOf(mWire, mMode);
      hh = mDiv + 1;
      total = hh * 18;
      m = cyc - startCyc;
      idx = 0;
      if (active && m >= 0) begin
        d = m / hh - 1;
        if (d < 0) d = 0;
        if (d > 16) d = 16;
        idx = pha ? ((d == 0) ? 0 : (d - 1) / 2) : d / 2;
        if (idx > 7) idx = 7;
        expCs = 4'hF;
        if (m < total) expCs[mSlv] = 1'b0;
        chk(csN == expCs, "R6/R7 csN", 32'(csN), 32'(expCs));
        chk(busy == (m < total), "R7 busy", 32'(busy), 32'(m < total));
        chk(done == (m == total), "R10 done", 32'(done), 32'(m == total));
        chk(sclk == ((m < total) ? (pol ^ d[0]) : pol), "R3 sclk", 32'(sclk),
            32'((m < total) ? (pol ^ d[0]) : pol));
        if (m < total)
          chk(mosi == bitAt(mTx, idx, mLsb), "R3/R5 mosi", 32'(mosi), 32'(bitAt(mTx, idx, mLsb)));
        if (m == total) begin
          chk(rxWord == slvWord, "R8 rxWord", 32'(rxWord), 32'(slvWord));
          lastRx = slvWord;
          active = 1'b0;
        end
      end else begin
        chk(csN == 4'hF, "R6 idle csN", 32'(csN), 32'hF);
        chk(!busy && !done, "R10 idle busy/done", 32'({busy, done}), 32'h0);
        chk(sclk == pol, "R2 idle sclk", 32'(sclk), 32'(pol));
        chk(rxWord == lastRx, "R10 rx hold", 32'(rxWord), 32'(lastRx));
      end
      miso = bitAt(slvWord, idx, mLsb);
    end
  end

  task automatic setCfg(input logic w, input logic [1:0] md, input logic lsb, input int dv, input int sl);
    @(negedge clk);
    cfgWire = w; cfgMode = md; cfgLsbFirst = lsb; cfgDiv = 8'(dv); cfgSlave = 2'(sl);
    cfgWe = 1'b1;
    @(posedge clk);
    if (!active) begin
      mWire = w; mMode = md; mLsb = lsb; mDiv = dv; mSlv = sl;
    end
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic beginXfer(input logic [7:0] tx, input logic [7:0] sw);
    @(negedge clk);
    txWord = tx; start = 1'b1;
    slvWord = sw; mTx = tx;
    startCyc = cyc + 1;
    active = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitXfer();
    while (active) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(csN == 4'hF, "R1 csN", 32'(csN), 32'hF);
    chk(!busy && !done && !sclk, "R1 busy/done/sclk", 32'({busy, done, sclk}), 32'h0);
    chk(rxWord == 8'h00, "R1 rxWord", 32'(rxWord), 32'h0);

    tag = "R3 mode0";        setCfg(0, 2'd0, 0, 0, 1); beginXfer(8'hA5, 8'h3C); waitXfer();
    tag = "R3 mode1";        setCfg(0, 2'd1, 0, 2, 2); beginXfer(8'h96, 8'hE1); waitXfer();
    tag = "R2 mode2";        setCfg(0, 2'd2, 0, 1, 3); beginXfer(8'h5A, 8'h81); waitXfer();
    tag = "R5 mode3 lsb";    setCfg(0, 2'd3, 1, 1, 0); beginXfer(8'hC1, 8'h7E); waitXfer();
    tag = "R4 wire std";     setCfg(1, 2'd2, 0, 3, 2); beginXfer(8'h3B, 8'hD4); waitXfer();
    tag = "R4 wire alt lsb"; setCfg(1, 2'd1, 1, 0, 1); beginXfer(8'hE7, 8'h18); waitXfer();

    // R9: writes and start during a frame are ignored
    tag = "R9 busy writes";
    setCfg(0, 2'd3, 0, 2, 0);
    beginXfer(8'h4C, 8'hB2);
    repeat (5) @(negedge clk);
    setCfg(0, 2'd0, 1, 0, 3);
    @(negedge clk);
    txWord = 8'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitXfer();
    chk(sclk == 1'b1, "R9 idle sclk keeps old polarity", 32'(sclk), 32'h1);
    tag = "R9 next frame old cfg";
    beginXfer(8'h0F, 8'hF0); waitXfer();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule